// File: doc/BRIEF.md
# Single-to-Half Precision Float Converter

This block turns an IEEE 754 binary32 word into a binary16 word. A valid strobe goes with each input word. The result and its valid strobe come out a fixed two cycles later. The block accepts one word per cycle, and gaps in the input stream pass straight through. Every input class gets its correct result:

- normal values that stay normal;
- small values that land in the half-precision denormal range;
- values too large for half precision;
- zeros and binary32 denormals;
- infinities and NaNs.

Every finite result is rounded to nearest, with ties going to the even neighbour.

Three status bits go with each result. The first shows that a finite input overflowed to infinity. The second shows an underflow: the input was tiny and precision was lost. The third shows that any nonzero bits were thrown away. Encodings in this brief use binary16 fields as follows: sign at bit 15, a 5-bit exponent with bias 15 at bits 14:10, and a 10-bit fraction at bits 9:0. Binary32 uses sign at bit 31, an 8-bit exponent with bias 127 at bits 30:23, and a 23-bit fraction.

Top module: `f2h_conv`

## Requirements
- R1: Each cycle with `in_vld` high produces exactly one cycle with `out_vld` high, two rising edges later, in the same order. While `out_vld` is low the result and flag outputs hold their previous values.
- R2: An input with biased exponent 113 to 142 gives half exponent (e - 112). The fraction is the top 10 input fraction bits, rounded to nearest-even on the 13 discarded bits. A carry out of the fraction increments the exponent.
- R3: An input with biased exponent 143 to 254, or one whose rounding carries past half exponent 30, gives signed infinity (0x7C00 with the sign kept). It sets the overflow and inexact flags.
- R4: An input with biased exponent 102 to 112 gives a half denormal. The significand with its hidden one is shifted right by (126 - e) places, then rounded to nearest-even. The largest denormal can round up into 0x0400, the smallest normal. An exponent-102 input with a nonzero fraction rounds up to 0x0001.
- R5: An input with biased exponent 0 to 101 gives a zero with the input's sign. A nonzero input of this kind sets the underflow and inexact flags. A true zero sets no flag.
- R6: An infinite input (exponent 255, fraction 0) gives half infinity of the same sign and sets no flag.
- R7: A NaN input (exponent 255, nonzero fraction), of either sign, gives exponent 31 with fraction bit 9 set and the top 9 input fraction bits below it. The sign is kept and no flag is set.
- R8: The inexact flag is set exactly when the result is not equal to the input value. The underflow flag is set exactly when the result is inexact and the input lies below 2^-14 (biased exponent 112 or below, before rounding).
- R9: During reset `out_vld`, `out_data` and all three flags are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Input word valid |
| in_data | input | 32 | Binary32 operand |
| out_vld | output | 1 | Result valid, two cycles after `in_vld` |
| out_data | output | 16 | Binary16 result |
| out_ovf | output | 1 | Finite input overflowed to infinity |
| out_unf | output | 1 | Tiny and inexact result |
| out_inx | output | 1 | Discarded bits were nonzero |

## Verification
The two functions that can act in the same cycle on one word are rounding and a range change. A round-up carry can push the largest finite value into infinity and overflow. It can also push the largest denormal into the smallest normal while the underflow flag is still raised.

Directed words sit exactly at these edges: a tie at 65520 with an odd mantissa, values just below it, and an exponent-112 input with an all-ones fraction. Constrained random words cluster around exponents 102, 112, 113 and 142. Each result and its three flags are compared with a bench model that computes the scaled quotient and remainder directly.

// File: rtl/f2h_pkg.sv
package f2h_pkg;

  // Field widths of the two formats.
  localparam int SP_EW   = 8;
  localparam int SP_FW   = 23;
  localparam int HP_EW   = 5;
  localparam int HP_FW   = 10;
  localparam int SP_BIAS = 127;
  localparam int HP_BIAS = 15;

  localparam int SP_W    = 1 + SP_EW + SP_FW;
  localparam int HP_W    = 1 + HP_EW + HP_FW;
  localparam int MAG_W   = HP_EW + HP_FW;
  localparam int DROP    = SP_FW - HP_FW;
  localparam int EXP_OFS = SP_BIAS - HP_BIAS;
  localparam int HP_EMAX = (1 << HP_EW) - 1;
  localparam int SP_EMAX = (1 << SP_EW) - 1;

  // Exponent thresholds derived from the two biases.
  localparam int NORM_LO = EXP_OFS + 1;
  localparam int OVF_LO  = EXP_OFS + HP_EMAX;
  localparam int SH_BASE = SP_BIAS - 1;
  localparam int SIG_W   = SP_FW + 2;
  localparam int SH_MAX  = SIG_W;
  localparam int DEN_LO  = SH_BASE - (SP_FW + 1);
  localparam int SH_W    = $clog2(SH_MAX + 1);
  localparam int PL_W    = HP_FW - 1;

  typedef enum logic [2:0] {
    CL_ZERO = 3'd0,
    CL_FIN  = 3'd1,
    CL_OVF  = 3'd2,
    CL_INF  = 3'd3,
    CL_NAN  = 3'd4
  } cls_e;

  typedef struct packed {
    logic             sign;
    cls_e             cls;
    logic [MAG_W-1:0] mag;
    logic             grd;
    logic             stk;
    logic             tiny;
    logic [PL_W-1:0]  payload;
  } dec_t;

endpackage

// File: rtl/f2h_decode.sv
module f2h_decode
  import f2h_pkg::*;
(
  input  logic [SP_W-1:0] op,
  output dec_t            dec
);

  logic [SP_EW-1:0] exp_in;
  logic [SP_FW-1:0] frac_in;
  logic [SP_EW-1:0] exp_half;
  logic [SH_W-1:0]  sh;
  logic [SIG_W-1:0] sig;
  logic [SIG_W-1:0] shifted;
  logic [SIG_W-1:0] low_mask;

  assign exp_in  = op[SP_W-2 -: SP_EW];
  assign frac_in = op[SP_FW-1:0];
  assign sig     = {1'b0, 1'b1, frac_in};
  assign exp_half = exp_in - SP_EW'(EXP_OFS);

  // Right shift for the denormal range, clamped so that tiny values flush.
  always_comb begin
    if (exp_in >= SP_EW'(DEN_LO)) sh = SH_W'(SH_BASE) - SH_W'(exp_in);
    else                          sh = SH_W'(SH_MAX);
  end

  assign shifted  = sig >> sh;
  assign low_mask = (SIG_W'(1) << (sh - SH_W'(1))) - SIG_W'(1);

  always_comb begin
    dec         = '0;
    dec.sign    = op[SP_W-1];
    dec.payload = frac_in[SP_FW-1 -: PL_W];
    if (exp_in == SP_EW'(SP_EMAX)) begin
      dec.cls = (frac_in != '0) ? CL_NAN : CL_INF;
    end else if (exp_in == '0) begin
      dec.cls  = CL_ZERO;
      dec.stk  = (frac_in != '0);
      dec.tiny = 1'b1;
    end else if (exp_in >= SP_EW'(OVF_LO)) begin
      dec.cls = CL_OVF;
    end else if (exp_in >= SP_EW'(NORM_LO)) begin
      dec.cls = CL_FIN;
      dec.mag = {exp_half[HP_EW-1:0], frac_in[SP_FW-1 -: HP_FW]};
      dec.grd = frac_in[DROP-1];
      dec.stk = (frac_in[DROP-2:0] != '0);
    end else begin
      dec.cls  = CL_FIN;
      dec.tiny = 1'b1;
      dec.mag  = {{HP_EW{1'b0}}, shifted[HP_FW-1:0]};
      dec.grd  = sig[sh - SH_W'(1)];
      dec.stk  = ((sig & low_mask) != '0);
    end
  end

endmodule

// File: rtl/f2h_round.sv
module f2h_round
  import f2h_pkg::*;
(
  input  dec_t            dec,
  output logic [HP_W-1:0] res,
  output logic            ovf,
  output logic            unf,
  output logic            inx
);

  localparam logic [MAG_W-1:0] INF_MAG = {{HP_EW{1'b1}}, {HP_FW{1'b0}}};

  logic             up;
  logic [MAG_W:0]   sum;
  logic             carry_inf;

  assign up        = dec.grd & (dec.stk | dec.mag[0]);
  assign sum       = {1'b0, dec.mag} + {{MAG_W{1'b0}}, up};
  assign carry_inf = (sum[MAG_W-1 -: HP_EW] == {HP_EW{1'b1}});

  always_comb begin
    res = {dec.sign, {MAG_W{1'b0}}};
    ovf = 1'b0;
    unf = 1'b0;
    inx = 1'b0;
    unique case (dec.cls)
      CL_NAN: res = {dec.sign, {HP_EW{1'b1}}, 1'b1, dec.payload};
      CL_INF: res = {dec.sign, INF_MAG};
      CL_OVF: begin
        res = {dec.sign, INF_MAG};
        ovf = 1'b1;
        inx = 1'b1;
      end
      CL_ZERO: begin
        inx = dec.stk;
        unf = dec.stk;
      end
      CL_FIN: begin
        inx = dec.grd | dec.stk;
        unf = dec.tiny & (dec.grd | dec.stk);
        if (carry_inf) begin
          res = {dec.sign, INF_MAG};
          ovf = 1'b1;
        end else begin
          res = {dec.sign, sum[MAG_W-1:0]};
        end
      end
      default: res = {dec.sign, {MAG_W{1'b0}}};
    endcase
  end

endmodule

// File: rtl/f2h_conv.sv
module f2h_conv
  import f2h_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_vld,
  input  logic [31:0] in_data,
  output logic        out_vld,
  output logic [15:0] out_data,
  output logic        out_ovf,
  output logic        out_unf,
  output logic        out_inx
);

  dec_t            dec_d;
  dec_t            dec_q;
  logic            v1_q;
  logic [HP_W-1:0] res_d;
  logic            ovf_d;
  logic            unf_d;
  logic            inx_d;

  f2h_decode u_decode (
    .op  (in_data),
    .dec (dec_d)
  );

  // Stage 1: classification and alignment, loaded only on a valid word.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q  <= 1'b0;
      dec_q <= '0;
    end else begin
      v1_q <= in_vld;
      if (in_vld) dec_q <= dec_d;
    end
  end

  f2h_round u_round (
    .dec (dec_q),
    .res (res_d),
    .ovf (ovf_d),
    .unf (unf_d),
    .inx (inx_d)
  );

  // Stage 2: rounded result and flags, held between valid words.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_data <= '0;
      out_ovf  <= 1'b0;
      out_unf  <= 1'b0;
      out_inx  <= 1'b0;
    end else begin
      out_vld <= v1_q;
      if (v1_q) begin
        out_data <= res_d;
        out_ovf  <= ovf_d;
        out_unf  <= unf_d;
        out_inx  <= inx_d;
      end
    end
  end

  // R1: valid travels through both stages, nothing extra appears.
  p_fill_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> v1_q);
  p_drain_r1: assert property (@(posedge clk) disable iff (!rst_n)
    v1_q |=> out_vld);
  p_no_spurious_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !v1_q |=> !out_vld);
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !v1_q |=> $stable(out_data));

  // R3: the overflow flag only accompanies an infinity.
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && out_ovf) |-> (out_data[14:0] == 15'h7C00));

  // R7: a NaN leaving the block is always quiet.
  p_nan_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && out_data[14:10] == 5'h1F && out_data[9:0] != 10'h0) |-> out_data[9]);

  // R8: underflow never appears without inexact.
  p_unf_inx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && out_unf) |-> out_inx);

endmodule

// File: tb/test_f2h_conv.sv
`timescale 1ns/1ps
module test_f2h_conv;

  logic        clk;
  logic        rst_n;
  logic        in_vld;
  logic [31:0] in_data;
  logic        out_vld;
  logic [15:0] out_data;
  logic        out_ovf;
  logic        out_unf;
  logic        out_inx;

  f2h_conv i_f2h_conv (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (in_vld),
    .in_data  (in_data),
    .out_vld  (out_vld),
    .out_data (out_data),
    .out_ovf  (out_ovf),
    .out_unf  (out_unf),
    .out_inx  (out_inx)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct {
    logic [31:0] op;
    logic [18:0] exp;
    int          due;
    string       req;
  } pend_t;

  pend_t pend[$];
  int    checks   = 0;
  int    failures = 0;
  int    cyc      = 0;
  bit    done     = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Reference: scale to the target quantum, round by remainder.
  function automatic logic [18:0] ref_conv(input logic [31:0] x);
    logic       s;
    int         e;
    int         big_e;
    int         q;
    int         k;
    int         ex;
    longint     m;
    longint     n;
    longint     rem;
    longint     half;
    logic       inx;
    logic       unf;
    logic [14:0] bits;
    s = x[31];
    e = int'(x[30:23]);
    if (e == 255) begin
      if (x[22:0] != 0) return {3'b000, s, 5'h1F, 1'b1, x[22:14]};
      return {3'b000, s, 15'h7C00};
    end
    if (e == 0) begin
      big_e = -126;
      m = longint'(x[22:0]);
    end else begin
      big_e = e - 127;
      m = longint'(x[22:0]) + (longint'(1) << 23);
    end
    if (m == 0) return {3'b000, s, 15'h0000};
    q = (big_e - 10 > -24) ? big_e - 10 : -24;
    k = q - big_e + 23;
    if (k > 60) k = 60;
    n    = m >> k;
    rem  = m - (n << k);
    half = longint'(1) << (k - 1);
    if (rem > half || (rem == half && n[0])) n = n + 1;
    inx = (rem != 0);
    unf = (big_e < -14) && inx;
    if (q == -24) begin
      bits = n[14:0];
    end else begin
      if (n == 2048) begin
        n = 1024;
        q = q + 1;
      end
      ex = q + 25;
      if (ex >= 31) return {1'b1, 1'b0, 1'b1, s, 15'h7C00};
      bits = {ex[4:0], n[9:0]};
    end
    return {inx, unf, 1'b0, s, bits};
  endfunction

  function automatic string req_of(input logic [31:0] x);
    int e;
    e = int'(x[30:23]);
    if (e == 255) return (x[22:0] != 0) ? "R7" : "R6";
    if (e >= 143) return "R3";
    if (e >= 113) return "R2";
    if (e >= 102) return "R4";
    return "R5";
  endfunction

  task automatic send(input logic [31:0] x);
    pend_t p;
    p.op  = x;
    p.exp = ref_conv(x);
    p.due = cyc + 2;
    p.req = req_of(x);
    pend.push_back(p);
    in_vld  = 1'b1;
    in_data = x;
    @(negedge clk);
    in_vld  = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Monitor: compare every valid result, check timing and holding.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_vld) begin
        if (pend.size() == 0) begin
          checks++;
          failures++;
          $display("FAIL R1 unexpected out_vld got=%h exp=none", out_data);
        end else begin
          pend_t p;
          p = pend.pop_front();
          checks++;
          if (cyc != p.due) begin
            failures++;
            $display("FAIL R1 latency in=%h got_cycle=%0d exp_cycle=%0d", p.op, cyc, p.due);
          end
          checks++;
          if (out_data !== p.exp[15:0]) begin
            failures++;
            $display("FAIL %s in=%h got=%h exp=%h", p.req, p.op, out_data, p.exp[15:0]);
          end
          checks++;
          if ({out_inx, out_unf, out_ovf} !== p.exp[18:16]) begin
            failures++;
            $display("FAIL R8 %s flags in=%h got=%b exp=%b", p.req, p.op,
                     {out_inx, out_unf, out_ovf}, p.exp[18:16]);
          end
        end
      end else if (pend.size() != 0 && pend[0].due < cyc) begin
        checks++;
        failures++;
        $display("FAIL R1 missing result in=%h got=none exp_cycle=%0d", pend[0].op, pend[0].due);
        void'(pend.pop_front());
      end
      if (cyc > 150000) begin
        failures++;
        $display("FAIL R1 watchdog expired got=%0d exp<150000", cyc);
        finish_run();
      end
    end
  end

  initial begin
    logic [15:0] held;
    rst_n   = 1'b0;
    in_vld  = 1'b0;
    in_data = '0;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    checks++;
    if (out_vld !== 1'b0 || out_data !== 16'h0 || {out_ovf, out_unf, out_inx} !== 3'b000) begin
      failures++;
      $display("FAIL R9 reset state got=%b_%h exp=0_0000", out_vld, out_data);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // Directed corners: R2 R3 R4 R5 R6 R7.
    send(32'h0000_0000);
    send(32'h8000_0000);
    send(32'h3F80_0000);
    send(32'hC000_0000);
    send(32'h3F80_1000);
    send(32'h3F80_3000);
    send(32'h477F_E000);
    send(32'h477F_EFFF);
    send(32'h477F_F000);
    send(32'hC77F_F000);
    send(32'h4780_0000);
    send(32'h7F7F_FFFF);
    send(32'h3880_0000);
    send(32'h387F_FFFF);
    send(32'hB87F_FFFF);
    send(32'h3380_0000);
    send(32'h3300_0000);
    send(32'h3300_0001);
    send(32'h32FF_FFFF);
    send(32'h0000_0001);
    send(32'h8040_0000);
    send(32'h7F80_0000);
    send(32'hFF80_0000);
    send(32'h7FC0_0000);
    send(32'h7F80_0001);
    send(32'hFF81_2345);
    repeat (4) @(negedge clk);

    // R1: results hold while no word is valid.
    held = out_data;
    repeat (3) @(negedge clk);
    checks++;
    if (out_data !== held) begin
      failures++;
      $display("FAIL R1 hold got=%h exp=%h", out_data, held);
    end

    // Back-to-back and gapped random stream around the range edges.
    for (int i = 0; i < 6000; i++) begin
      logic [31:0] x;
      logic [7:0]  e;
      int          mode;
      mode = int'($urandom % 5);
      x = $urandom;
      case (mode)
        0: ;
        1: begin
          e = 8'(98 + ($urandom % 50));
          x[30:23] = e;
        end
        2: begin
          x[30:23] = 8'd142;
          x[22:12] = 11'h7FF;
        end
        3: begin
          x[30:23] = 8'(($urandom % 2) ? 112 : 102);
          if ($urandom % 2) x[22:0] = 23'h7FFFFF - 23'($urandom % 8);
        end
        default: begin
          x[12:0] = ($urandom % 2) ? 13'h1000 : 13'h0000;
        end
      endcase
      if ($urandom % 4 == 0) @(negedge clk);
      send(x);
    end
    repeat (6) @(negedge clk);
    checks++;
    if (pend.size() != 0) begin
      failures++;
      $display("FAIL R1 undelivered got=%0d exp=0", pend.size());
    end
    finish_run();
  end

endmodule